// File: doc/BRIEF.md
# UART Register Block with Interrupt Aggregation

This block is the software-facing register layer of a small UART. A 32-bit word bus reaches six registers: a control word, a baud divisor word, a line/threshold register with live fill readback, an external-input configuration word, a combined interrupt status/mask register and a character data port. Control fields are decoded into plain outputs that steer the serial datapath (enables, framing, parity, loopback, break). Three control bits are command bits that fire single-cycle reset pulses toward the datapath instead of being stored.

Event reports arriving from the datapath on a 16-bit source vector are latched into status bits, while a handful of level-type sources are passed through live. Each source has a mask bit sixteen positions above its status bit, and a single registered interrupt line is raised whenever any status bit is set together with its mask. The receive-overrun source is sticky: software cannot clear it through the interrupt register, only by resetting the receive FIFO.

The bus address is a word index (byte offset divided by four); reads are registered and return data in the cycle after `rd_en`.

Top module: `uart_regblock`

## Requirements
- R1: Word 0 (control) stores and reads back bits 4:0 (receive timeout count), 11:8 (stop select), 13:12 (symbol size), 14 (break), 16 (receive even parity), 17 (receive parity enable), 18 (transmit even parity), 19 (transmit parity enable), 20 (loopback), 21 (receiver enable), 22 (transmitter enable) and 23 (baud generator enable); each field drives its own output, and all other bits read as zero.
- R2: Writing 1 to control bit 5, 6 or 7 raises `txdone_clr`, `rx_fifo_rst` or `tx_fifo_rst` respectively for exactly the one cycle after the write; these bits read back as zero.
- R3: Word 1 (baud divisor) and word 3 (external-input configuration) are full 32-bit read/write registers that drive `baud_word` and `ext_cfg`.
- R4: Word 2 stores DTR in bit 0, RTS in bit 1, receive threshold in bits 11:8 and transmit threshold in bits 15:12; bits 20:16 return the live `rx_fill` and bits 28:24 the live `tx_fill`; writes to any other bit are ignored.
- R5: Word 4 returns source status in bits 15:0 and the per-source mask in bits 31:16; the mask bits are read/write.
- R6: Level sources 3, 5, 9, 10 and 11 show the present value of their `src_in` bit, with no latching.
- R7: Every other source sets its status bit on any cycle its `src_in` bit is high; writing 1 to that status bit in word 4 clears it, and a set in the same cycle wins over the clear.
- R8: Source 7 (receive overrun) ignores write-one-to-clear and is cleared only by the `rx_fifo_rst` pulse.
- R9: Source 15 (transmit done) is also cleared by the `txdone_clr` pulse.
- R10: `irq` is high in the cycle after any source has both status and mask set, and low in the cycle after none has.
- R11: A write to word 5 pulses `fifo_wr` for one cycle with `fifo_wdata` equal to wdata bits 7:0; a read of word 5 returns `rx_char` zero-extended (bits 7:0 character, 8 frame error, 9 parity error, 10 break) and pulses `fifo_rd` for one cycle.
- R12: After reset every stored field, mask and latched status is zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 3 | Word index of the register |
| wdata | input | 32 | Bus write data |
| rdata | output | 32 | Registered read data |
| baud_word | output | 32 | Baud divisor word |
| rx_tmo_cnt | output | 5 | Receive timeout count |
| txdone_clr | output | 1 | TX-done reset pulse |
| rx_fifo_rst | output | 1 | Receive FIFO reset pulse |
| tx_fifo_rst | output | 1 | Transmit FIFO reset pulse |
| stop_sel | output | 4 | Stop-bit select (0x7 one, 0xF two) |
| sym_sel | output | 2 | Symbol size select (3 = 8 bits) |
| tx_break | output | 1 | Force break on the line |
| rx_par_even | output | 1 | Receive even parity |
| rx_par_en | output | 1 | Receive parity enable |
| tx_par_even | output | 1 | Transmit even parity |
| tx_par_en | output | 1 | Transmit parity enable |
| loopback | output | 1 | Internal loopback |
| rx_en | output | 1 | Receiver enable |
| tx_en | output | 1 | Transmitter enable |
| brg_en | output | 1 | Baud generator enable |
| ext_cfg | output | 32 | External-input configuration word |
| dtr | output | 1 | Data terminal ready |
| rts | output | 1 | Request to send |
| rx_thr | output | 4 | Receive FIFO threshold |
| tx_thr | output | 4 | Transmit FIFO threshold |
| rx_fill | input | 5 | Receive FIFO fill level |
| tx_fill | input | 5 | Transmit FIFO fill level |
| src_in | input | 16 | Interrupt source reports from the datapath |
| fifo_wr | output | 1 | Transmit character push pulse |
| fifo_wdata | output | 8 | Character to push |
| fifo_rd | output | 1 | Receive character pop pulse |
| rx_char | input | 11 | Head of receive FIFO with error flags |
| irq | output | 1 | Interrupt request |

## Verification
The bench walks every one of the sixteen sources with only its own mask bit set, so a design that latched a level source would keep reporting it after the input fell, and one that wired a mask to the wrong status bit would leave `irq` low or raise it for the wrong source. Receive overrun is hit with a write-one-to-clear and must survive it, then must vanish after a receive FIFO reset; a design treating it like the other events would clear early. A source firing in the same cycle as its clear must stay set, which catches a clear-priority update. All-ones writes to the control and line registers expose command bits that were stored instead of self-clearing, and read-only fill fields that could be overwritten.

// File: rtl/uart_regblock_pkg.sv
package uart_regblock_pkg;
  localparam int WORD_W = 3;

  typedef enum logic [WORD_W-1:0] {
    OFS_CTL  = 3'd0,
    OFS_BAUD = 3'd1,
    OFS_LINE = 3'd2,
    OFS_EXT  = 3'd3,
    OFS_IRQ  = 3'd4,
    OFS_DATA = 3'd5
  } reg_ofs_e;

  // storable bits of the control word and the line register
  localparam logic [31:0] CTL_KEEP  = 32'h00FF_7F1F;
  localparam logic [31:0] LINE_KEEP = 32'h0000_FF03;

  localparam int CMD_TXDONE = 5;
  localparam int CMD_RXRST  = 6;
  localparam int CMD_TXRST  = 7;
endpackage

// File: rtl/uart_cfg_regs.sv
module uart_cfg_regs
  import uart_regblock_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_ctl,
  input  logic        wr_baud,
  input  logic        wr_line,
  input  logic        wr_ext,
  input  logic [31:0] wdata,
  output logic [31:0] ctl_q,
  output logic [31:0] baud_q,
  output logic [31:0] line_q,
  output logic [31:0] ext_q,
  output logic        txdone_pls,
  output logic        rxrst_pls,
  output logic        txrst_pls
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q      <= '0;
      baud_q     <= '0;
      line_q     <= '0;
      ext_q      <= '0;
      txdone_pls <= 1'b0;
      rxrst_pls  <= 1'b0;
      txrst_pls  <= 1'b0;
    end else begin
      if (wr_ctl)  ctl_q  <= wdata & CTL_KEEP;
      if (wr_baud) baud_q <= wdata;
      if (wr_line) line_q <= wdata & LINE_KEEP;
      if (wr_ext)  ext_q  <= wdata;
      txdone_pls <= wr_ctl && wdata[CMD_TXDONE];
      rxrst_pls  <= wr_ctl && wdata[CMD_RXRST];
      txrst_pls  <= wr_ctl && wdata[CMD_TXRST];
    end
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int          NSRC       = 16,
  parameter logic [15:0] LEVEL_SRC  = 16'h0E28,
  parameter logic [15:0] STICKY_SRC = 16'h0080,
  parameter int          TXDONE_SRC = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_irq,
  input  logic [2*NSRC-1:0] wdata,
  input  logic [NSRC-1:0]   src_in,
  input  logic              rxrst_pls,
  input  logic              txdone_pls,
  output logic [NSRC-1:0]   stat,
  output logic [NSRC-1:0]   mask,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '0;
      irq  <= 1'b0;
    end else begin
      if (wr_irq) mask <= wdata[2*NSRC-1:NSRC];
      irq <= |(stat & mask);
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    if (LEVEL_SRC[g]) begin : g_level
      assign stat[g] = src_in[g];
    end else begin : g_event
      logic hold_q;
      logic clr;
      if (STICKY_SRC[g]) begin : g_sticky
        assign clr = rxrst_pls;
      end else if (g == TXDONE_SRC) begin : g_txdone
        assign clr = (wr_irq && wdata[g]) || txdone_pls;
      end else begin : g_w1c
        assign clr = wr_irq && wdata[g];
      end
      always_ff @(posedge clk) begin
        if (rst)            hold_q <= 1'b0;
        else if (src_in[g]) hold_q <= 1'b1;
        else if (clr)       hold_q <= 1'b0;
      end
      assign stat[g] = hold_q;
    end
  end
endmodule

// File: rtl/uart_regblock.sv
module uart_regblock
  import uart_regblock_pkg::*;
#(
  parameter int          FILL_W     = 5,
  parameter int          CHAR_W     = 8,
  parameter logic [15:0] LEVEL_SRC  = 16'h0E28,
  parameter logic [15:0] STICKY_SRC = 16'h0080
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [WORD_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [31:0]       baud_word,
  output logic [4:0]        rx_tmo_cnt,
  output logic              txdone_clr,
  output logic              rx_fifo_rst,
  output logic              tx_fifo_rst,
  output logic [3:0]        stop_sel,
  output logic [1:0]        sym_sel,
  output logic              tx_break,
  output logic              rx_par_even,
  output logic              rx_par_en,
  output logic              tx_par_even,
  output logic              tx_par_en,
  output logic              loopback,
  output logic              rx_en,
  output logic              tx_en,
  output logic              brg_en,
  output logic [31:0]       ext_cfg,
  output logic              dtr,
  output logic              rts,
  output logic [3:0]        rx_thr,
  output logic [3:0]        tx_thr,
  input  logic [FILL_W-1:0] rx_fill,
  input  logic [FILL_W-1:0] tx_fill,
  input  logic [15:0]       src_in,
  output logic              fifo_wr,
  output logic [CHAR_W-1:0] fifo_wdata,
  output logic              fifo_rd,
  input  logic [CHAR_W+2:0] rx_char,
  output logic              irq
);
  localparam int NSRC = 16;

  logic [31:0]     ctl_q, line_q;
  logic [NSRC-1:0] irq_stat, irq_mask;
  logic [31:0]     rd_mux;

  wire hit_ctl  = wr_en && (addr == OFS_CTL);
  wire hit_irq  = wr_en && (addr == OFS_IRQ);
  wire hit_data = wr_en && (addr == OFS_DATA);

  uart_cfg_regs cfg_i (
    .clk(clk), .rst(rst),
    .wr_ctl(hit_ctl),
    .wr_baud(wr_en && (addr == OFS_BAUD)),
    .wr_line(wr_en && (addr == OFS_LINE)),
    .wr_ext(wr_en && (addr == OFS_EXT)),
    .wdata(wdata),
    .ctl_q(ctl_q), .baud_q(baud_word), .line_q(line_q), .ext_q(ext_cfg),
    .txdone_pls(txdone_clr), .rxrst_pls(rx_fifo_rst), .txrst_pls(tx_fifo_rst)
  );

  uart_irq_ctrl #(
    .NSRC(NSRC), .LEVEL_SRC(LEVEL_SRC), .STICKY_SRC(STICKY_SRC), .TXDONE_SRC(15)
  ) irq_i (
    .clk(clk), .rst(rst),
    .wr_irq(hit_irq), .wdata(wdata), .src_in(src_in),
    .rxrst_pls(rx_fifo_rst), .txdone_pls(txdone_clr),
    .stat(irq_stat), .mask(irq_mask), .irq(irq)
  );

  // control field decode
  assign rx_tmo_cnt  = ctl_q[4:0];
  assign stop_sel    = ctl_q[11:8];
  assign sym_sel     = ctl_q[13:12];
  assign tx_break    = ctl_q[14];
  assign rx_par_even = ctl_q[16];
  assign rx_par_en   = ctl_q[17];
  assign tx_par_even = ctl_q[18];
  assign tx_par_en   = ctl_q[19];
  assign loopback    = ctl_q[20];
  assign rx_en       = ctl_q[21];
  assign tx_en       = ctl_q[22];
  assign brg_en      = ctl_q[23];
  assign dtr         = line_q[0];
  assign rts         = line_q[1];
  assign rx_thr      = line_q[11:8];
  assign tx_thr      = line_q[15:12];

  always_comb begin
    rd_mux = '0;
    case (addr)
      OFS_CTL:  rd_mux = ctl_q;
      OFS_BAUD: rd_mux = baud_word;
      OFS_LINE: begin
        rd_mux = line_q;
        rd_mux[16 +: FILL_W] = rx_fill;
        rd_mux[24 +: FILL_W] = tx_fill;
      end
      OFS_EXT:  rd_mux = ext_cfg;
      OFS_IRQ:  rd_mux = {irq_mask, irq_stat};
      OFS_DATA: rd_mux[CHAR_W+2:0] = rx_char;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata      <= '0;
      fifo_wr    <= 1'b0;
      fifo_rd    <= 1'b0;
      fifo_wdata <= '0;
    end else begin
      if (rd_en) rdata <= rd_mux;
      fifo_wr <= hit_data;
      fifo_rd <= rd_en && (addr == OFS_DATA);
      if (hit_data) fifo_wdata <= wdata[CHAR_W-1:0];
    end
  end
endmodule

// File: rtl/uart_regblock_chk.sv
module uart_regblock_chk
  import uart_regblock_pkg::*;
#(
  parameter logic [15:0] LEVEL_SRC = 16'h0E28
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [WORD_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [15:0]       src_in,
  input logic              rx_fifo_rst,
  input logic              tx_fifo_rst,
  input logic              fifo_wr,
  input logic              irq,
  input logic [15:0]       irq_stat,
  input logic [15:0]       irq_mask
);
  // R2
  rx_rst_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rx_fifo_rst |-> $past(wr_en && addr == OFS_CTL && wdata[CMD_RXRST]));
  // R2
  tx_rst_cause_chk: assert property (@(posedge clk) disable iff (rst)
    tx_fifo_rst |-> $past(wr_en && addr == OFS_CTL && wdata[CMD_TXRST]));
  // R11
  push_cause_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> $past(wr_en && addr == OFS_DATA));
  // R6
  level_live_chk: assert property (@(posedge clk) disable iff (rst)
    ((irq_stat ^ src_in) & LEVEL_SRC) == 16'h0);
  // R7
  event_latch_chk: assert property (@(posedge clk) disable iff (rst)
    ((src_in & ~LEVEL_SRC) != 16'h0) |=>
      ((irq_stat & $past(src_in & ~LEVEL_SRC)) == $past(src_in & ~LEVEL_SRC)));
  // R8
  overrun_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_stat[7] && !rx_fifo_rst) |=> irq_stat[7]);
  // R10
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    ((irq_stat & irq_mask) != 16'h0) |=> irq);
  // R10
  irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    ((irq_stat & irq_mask) == 16'h0) |=> !irq);
endmodule

bind uart_regblock uart_regblock_chk #(.LEVEL_SRC(LEVEL_SRC)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .src_in(src_in), .rx_fifo_rst(rx_fifo_rst), .tx_fifo_rst(tx_fifo_rst),
  .fifo_wr(fifo_wr), .irq(irq), .irq_stat(irq_stat), .irq_mask(irq_mask)
);

// File: tb/uart_regblock_tb_top.sv
module uart_regblock_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] LEVELS = 16'h0E28;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0, rdata, baud_word, ext_cfg;
  logic [4:0] rx_tmo_cnt, rx_fill = '0, tx_fill = '0;
  logic txdone_clr, rx_fifo_rst, tx_fifo_rst, tx_break, rx_par_even, rx_par_en;
  logic tx_par_even, tx_par_en, loopback, rx_en, tx_en, brg_en, dtr, rts;
  logic [3:0] stop_sel, rx_thr, tx_thr;
  logic [1:0] sym_sel;
  logic [15:0] src_in = '0;
  logic fifo_wr, fifo_rd, irq;
  logic [7:0] fifo_wdata;
  logic [10:0] rx_char = '0;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regblock dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0; d = rdata;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    logic [31:0] v, p;
    logic [31:0] pats [4] = '{32'hFFFF_FFFF, 32'h00A5_5A5A, 32'h00F0_370F, 32'h0F0F_F0F0};
    tick(3); rst = 1'b0; tick(1);

    // R12 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v); chk(v == 32'h0, "R12", v, 32'h0);
    end
    chk(irq == 1'b0, "R12 irq", {31'h0, irq}, 32'h0);

    // R1 R2 control sweep
    foreach (pats[i]) begin
      p = pats[i];
      wr(3'd0, p);
      chk({txdone_clr, rx_fifo_rst, tx_fifo_rst} == {p[5], p[6], p[7]}, "R2 pulse",
          {29'h0, txdone_clr, rx_fifo_rst, tx_fifo_rst}, {29'h0, p[5], p[6], p[7]});
      tick(1);
      chk({txdone_clr, rx_fifo_rst, tx_fifo_rst} == 3'b000, "R2 one cycle",
          {29'h0, txdone_clr, rx_fifo_rst, tx_fifo_rst}, 32'h0);
      rd(3'd0, v);
      chk(v == (p & 32'h00FF_7F1F), "R1 readback", v, p & 32'h00FF_7F1F);
      chk({brg_en, tx_en, rx_en, loopback, tx_par_en, tx_par_even, rx_par_en, rx_par_even,
           tx_break, sym_sel, stop_sel, rx_tmo_cnt} ==
          {p[23:16], p[14], p[13:12], p[11:8], p[4:0]}, "R1 fields",
          {8'h0, brg_en, tx_en, rx_en, loopback, tx_par_en, tx_par_even, rx_par_en,
           rx_par_even, tx_break, sym_sel, stop_sel, rx_tmo_cnt},
          {8'h0, p[23:16], p[14], p[13:12], p[11:8], p[4:0]});
    end
    wr(3'd0, 32'h0);

    // R3 baud and external configuration
    foreach (pats[i]) begin
      wr(3'd1, pats[i]); wr(3'd3, ~pats[i]);
      rd(3'd1, v); chk(v == pats[i] && baud_word == pats[i], "R3 baud", v, pats[i]);
      rd(3'd3, v); chk(v == ~pats[i] && ext_cfg == ~pats[i], "R3 ext", v, ~pats[i]);
    end

    // R4 line register with live fill levels
    rx_fill = 5'h13; tx_fill = 5'h0A;
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, v);
    chk(v == 32'h0A13_FF03, "R4 readback", v, 32'h0A13_FF03);
    chk({dtr, rts, rx_thr, tx_thr} == 10'h3FF, "R4 fields", {22'h0, dtr, rts, rx_thr, tx_thr}, 32'h3FF);
    rx_fill = 5'h01; tx_fill = 5'h1F;
    wr(3'd2, 32'h0000_5A01);
    rd(3'd2, v);
    chk(v == 32'h1F01_5A01, "R4 live fill", v, 32'h1F01_5A01);

    // R5 R6 R7 R8 R9 R10 per-source sweep
    for (int n = 0; n < 16; n++) begin
      logic [15:0] b;
      b = 16'(1) << n;
      wr(3'd4, {16'h0, 16'hFFFF});
      wr(3'd0, 32'h0000_0060);
      tick(2);
      if (LEVELS[n]) begin
        src_in = b; tick(2);
        chk(irq == 1'b0, "R10 masked", {31'h0, irq}, 32'h0);
        wr(3'd4, {b, 16'h0}); tick(2);
        rd(3'd4, v);
        chk(v == {b, b}, "R6 live high", v, {b, b});
        chk(irq == 1'b1, "R10 raise", {31'h0, irq}, 32'h1);
        src_in = '0; tick(2);
        rd(3'd4, v);
        chk(v == {b, 16'h0}, "R6 live low", v, {b, 16'h0});
        chk(irq == 1'b0, "R10 fall", {31'h0, irq}, 32'h0);
      end else begin
        src_in = b; tick(1); src_in = '0; tick(2);
        chk(irq == 1'b0, "R10 masked", {31'h0, irq}, 32'h0);
        wr(3'd4, {b, 16'h0}); tick(2);
        rd(3'd4, v);
        chk(v == {b, b}, "R5 R7 latched", v, {b, b});
        chk(irq == 1'b1, "R10 raise", {31'h0, irq}, 32'h1);
        wr(3'd4, {b, b}); tick(2);
        rd(3'd4, v);
        if (n == 7) begin
          chk(v == {b, b}, "R8 ignores clear", v, {b, b});
          wr(3'd0, 32'h0000_0040); tick(2);
          rd(3'd4, v);
          chk(v == {b, 16'h0}, "R8 fifo reset clears", v, {b, 16'h0});
        end else begin
          chk(v == {b, 16'h0}, "R7 w1c", v, {b, 16'h0});
        end
        chk(irq == 1'b0, "R10 fall", {31'h0, irq}, 32'h0);
        if (n == 15) begin
          src_in = b; tick(1); src_in = '0;
          wr(3'd0, 32'h0000_0020); tick(2);
          rd(3'd4, v);
          chk(v == {b, 16'h0}, "R9 txdone reset", v, {b, 16'h0});
        end
        if (n == 1) begin
          src_in = b; wr(3'd4, {b, b}); src_in = '0; tick(1);
          rd(3'd4, v);
          chk(v == {b, b}, "R7 set beats clear", v, {b, b});
        end
      end
    end

    // R11 data port
    wr(3'd5, 32'h0000_01C3);
    chk(fifo_wr == 1'b1 && fifo_wdata == 8'hC3, "R11 push", {23'h0, fifo_wr, fifo_wdata}, 32'h1C3);
    tick(1);
    chk(fifo_wr == 1'b0, "R11 push once", {31'h0, fifo_wr}, 32'h0);
    rx_char = 11'h5A7;
    rd(3'd5, v);
    chk(v == 32'h0000_05A7, "R11 read char", v, 32'h5A7);
    chk(fifo_rd == 1'b1, "R11 pop", {31'h0, fifo_rd}, 32'h1);
    tick(1);
    chk(fifo_rd == 1'b0, "R11 pop once", {31'h0, fifo_rd}, 32'h0);

    finish_run();
  end
endmodule